// File: doc/BRIEF.md
# Receive-Path DC Offset Calibration Unit

This block sits in a dual-channel (I and Q) receive path, between the decimation filter and the serial output stage. Each channel holds a signed offset register. A calibration strobe clears that register while the strobe is high. When the strobe drops, the register captures the next accepted filter result. That result measures the DC offset of the analog front end, provided the front end was switched to a zero input beforehand. Every accepted filter result is then corrected by subtracting the stored offset, clamped to the word range, and passed on with a valid flag.

Two sleep controls are shared by both channels. The offset registers hold their contents through sleep. Filter results are discarded while either sleep control is high and for a settling window after both are released. A status output reports a calibration strobe that was released too early. A second status output stays set from reset until the first offset capture, because the register contents at that point are not a real measurement.

Top module: `dc_offset_cal`

## Requirements
- R1: In every clock edge where `cal_i` is high, both offset registers are set to zero and the accepted results pass through unchanged (offset zero).
- R2: After `cal_i` falls, the first accepted result on each channel is loaded into that channel's offset register. Later results do not reload it until the next calibration.
- R3: An accepted result (`res_vld_i` high, no sleep, settled) appears one clock later on `out_i_o`/`out_q_o` as result minus offset, with `out_vld_o` high. Otherwise `out_vld_o` is low and the data outputs hold.
- R4: No wait state follows calibration. The captured result itself is output corrected by the new offset, which gives zero.
- R5: At each falling edge of `cal_i`, `cal_short_o` is updated one clock later. It becomes 1 if `cal_i` was high on fewer than `CAL_MIN_CYC` clock edges, and 0 otherwise. It holds between falls.
- R6: `cal_i` may stay high for any number of cycles. The offset stays zero and no flag is raised while it is high.
- R7: While `sleep_a_i` or `sleep_b_i` is high, results are ignored and the offset registers keep their values.
- R8: After both sleep inputs go low, results arriving on the next `SETTLE_CYC` clock edges are dropped.
- R9: `uncal_o` is 1 from reset until the first offset capture, and 0 afterwards.
- R10: The subtraction saturates to the most positive (2^(W-1)-1) and most negative (-2^(W-1)) codes instead of wrapping.
- R11: Synchronous reset `rst` clears both offsets, the capture-pending state, the strobe-width counter, `out_vld_o`, the data outputs and `cal_short_o`, and sets `uncal_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous reset, active high |
| cal_i | input | 1 | Calibration strobe |
| sleep_a_i | input | 1 | Sleep control 1 |
| sleep_b_i | input | 1 | Sleep control 2 |
| res_vld_i | input | 1 | Filter result strobe |
| res_i_i | input | DATA_W | Signed I filter result |
| res_q_i | input | DATA_W | Signed Q filter result |
| out_vld_o | output | 1 | Corrected result valid |
| out_i_o | output | DATA_W | Corrected I result |
| out_q_o | output | DATA_W | Corrected Q result |
| cal_short_o | output | 1 | Last strobe was too short |
| uncal_o | output | 1 | No calibration since reset |

## Verification
The bench builds the block with an 8-bit word, a 20-cycle minimum strobe width and a 5-cycle settling window. With the 8-bit word, saturation at +127 and -128 is reached by ordinary values. The short strobe width lets random stimulus produce both too-short and long-enough strobes many times. The short settling window lets sleep release, the dropped-result window and captures that follow a wake-up overlap often within a few thousand cycles.

// File: rtl/dcal_pkg.sv
package dcal_pkg;
  // Clamp a - b into the signed range of a w-bit word.
  function automatic longint sat_sub(input longint a, input longint b, input int unsigned w);
    longint d;
    longint hi;
    longint lo;
    d  = a - b;
    hi = (longint'(1) <<< (w - 1)) - 1;
    lo = -hi - 1;
    if (d > hi) return hi;
    if (d < lo) return lo;
    return d;
  endfunction
endpackage

// File: rtl/dcal_chan.sv
module dcal_chan import dcal_pkg::*; #(
  parameter int unsigned W = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                cal,
  input  logic                cap,
  input  logic                ok,
  input  logic signed [W-1:0] res,
  output logic signed [W-1:0] off,
  output logic signed [W-1:0] dout
);
  logic signed [W-1:0] off_q;
  logic signed [W-1:0] off_eff;
  logic signed [W-1:0] out_q;
  logic signed [W-1:0] corr;

  always_comb begin
    if (cal)      off_eff = '0;
    else if (cap) off_eff = res;
    else          off_eff = off_q;
    corr = W'(sat_sub(longint'(res), longint'(off_eff), W));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      off_q <= '0;
      out_q <= '0;
    end else begin
      if (cal)      off_q <= '0;
      else if (cap) off_q <= res;
      if (ok)       out_q <= corr;
    end
  end

  assign off  = off_q;
  assign dout = out_q;
endmodule

// File: rtl/dcal_calwidth.sv
module dcal_calwidth #(
  parameter int unsigned MIN_CYC = 609
) (
  input  logic clk,
  input  logic rst,
  input  logic cal,
  output logic cal_fall,
  output logic cw_short,
  output logic short_flag
);
  localparam int unsigned CW = $clog2(MIN_CYC + 1);
  localparam logic [CW-1:0] LIM = CW'(MIN_CYC);

  logic [CW-1:0] cnt_q;
  logic          cal_q;
  logic          flag_q;

  assign cal_fall = cal_q & ~cal;
  assign cw_short = (cnt_q < LIM);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      cal_q  <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      cal_q <= cal;
      if (!cal)            cnt_q <= '0;
      else if (cnt_q < LIM) cnt_q <= cnt_q + 1'b1;
      if (cal_fall)        flag_q <= cw_short;
    end
  end

  assign short_flag = flag_q;
endmodule

// File: rtl/dcal_settle.sv
module dcal_settle #(
  parameter int unsigned SETTLE_CYC = 21
) (
  input  logic clk,
  input  logic rst,
  input  logic asleep,
  output logic settled
);
  localparam int unsigned SW = $clog2(SETTLE_CYC + 1);
  localparam logic [SW-1:0] TOP = SW'(SETTLE_CYC);

  logic [SW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)              cnt_q <= TOP;
    else if (asleep)      cnt_q <= '0;
    else if (cnt_q < TOP) cnt_q <= cnt_q + 1'b1;
  end

  assign settled = (cnt_q == TOP);
endmodule

// File: rtl/dc_offset_cal.sv
module dc_offset_cal #(
  parameter int unsigned DATA_W      = 16,
  parameter int unsigned CAL_MIN_CYC = 609,
  parameter int unsigned SETTLE_CYC  = 21
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cal_i,
  input  logic              sleep_a_i,
  input  logic              sleep_b_i,
  input  logic              res_vld_i,
  input  logic [DATA_W-1:0] res_i_i,
  input  logic [DATA_W-1:0] res_q_i,
  output logic              out_vld_o,
  output logic [DATA_W-1:0] out_i_o,
  output logic [DATA_W-1:0] out_q_o,
  output logic              cal_short_o,
  output logic              uncal_o
);
  logic asleep;
  logic settled;
  logic accept;
  logic cal_fall;
  logic cw_short;
  logic pend_q;
  logic pend_now;
  logic cap;
  logic vld_q;
  logic uncal_q;
  logic signed [DATA_W-1:0] off_i;
  logic signed [DATA_W-1:0] off_q;
  logic signed [DATA_W-1:0] dout_i;
  logic signed [DATA_W-1:0] dout_q;

  assign asleep   = sleep_a_i | sleep_b_i;
  assign accept   = res_vld_i & ~asleep & settled;
  assign pend_now = pend_q | cal_fall;
  assign cap      = pend_now & accept & ~cal_i;

  dcal_settle #(.SETTLE_CYC(SETTLE_CYC)) u_settle (
    .clk(clk), .rst(rst), .asleep(asleep), .settled(settled)
  );

  dcal_calwidth #(.MIN_CYC(CAL_MIN_CYC)) u_cw (
    .clk(clk), .rst(rst), .cal(cal_i),
    .cal_fall(cal_fall), .cw_short(cw_short), .short_flag(cal_short_o)
  );

  dcal_chan #(.W(DATA_W)) u_ch_i (
    .clk(clk), .rst(rst), .cal(cal_i), .cap(cap), .ok(accept),
    .res(res_i_i), .off(off_i), .dout(dout_i)
  );

  dcal_chan #(.W(DATA_W)) u_ch_q (
    .clk(clk), .rst(rst), .cal(cal_i), .cap(cap), .ok(accept),
    .res(res_q_i), .off(off_q), .dout(dout_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q  <= 1'b0;
      vld_q   <= 1'b0;
      uncal_q <= 1'b1;
    end else begin
      vld_q <= accept;
      if (cal_i || cap) pend_q <= 1'b0;
      else              pend_q <= pend_now;
      if (cap)          uncal_q <= 1'b0;
    end
  end

  assign out_vld_o = vld_q;
  assign out_i_o   = dout_i;
  assign out_q_o   = dout_q;
  assign uncal_o   = uncal_q;
endmodule

// File: rtl/dcal_chk.sv
module dcal_chk #(
  parameter int unsigned W = 16
) (
  input logic         clk,
  input logic         rst,
  input logic         cal_i,
  input logic         asleep,
  input logic         settled,
  input logic         cap,
  input logic         cal_fall,
  input logic         cw_short,
  input logic [W-1:0] res_i,
  input logic [W-1:0] res_q,
  input logic [W-1:0] off_i,
  input logic [W-1:0] off_q,
  input logic         out_vld_o,
  input logic         cal_short_o,
  input logic         uncal_o
);
  AST_CAL_CLEARS: assert property (@(posedge clk) disable iff (rst)
    cal_i |=> (off_i == '0 && off_q == '0)); // R1
  AST_CAPTURE_LOADS: assert property (@(posedge clk) disable iff (rst)
    cap |=> (off_i == $past(res_i) && off_q == $past(res_q))); // R2
  AST_SLEEP_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (asleep && !cal_i) |=> ($stable(off_i) && $stable(off_q))); // R7
  AST_SETTLE_GATE: assert property (@(posedge clk) disable iff (rst)
    (!settled || asleep) |=> !out_vld_o); // R8
  AST_SHORT_FLAG: assert property (@(posedge clk) disable iff (rst)
    cal_fall |=> (cal_short_o == $past(cw_short))); // R5
  AST_UNCAL_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (uncal_o && !cap) |=> uncal_o); // R9
endmodule

bind dc_offset_cal dcal_chk #(.W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .cal_i(cal_i), .asleep(asleep), .settled(settled),
  .cap(cap), .cal_fall(cal_fall), .cw_short(cw_short),
  .res_i(res_i_i), .res_q(res_q_i), .off_i(off_i), .off_q(off_q),
  .out_vld_o(out_vld_o), .cal_short_o(cal_short_o), .uncal_o(uncal_o)
);

// File: tb/tb_dc_offset_cal.sv
module tb_dc_offset_cal;
  localparam int W   = 8;
  localparam int MIN = 20;
  localparam int SET = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cal = 1'b0, sa = 1'b0, sb = 1'b0, vld = 1'b0;
  logic [W-1:0] ri = '0, rq = '0;
  logic out_vld, short_o, uncal;
  logic [W-1:0] oi, oq;

  int nchk = 0, nerr = 0;
  string ph = "R11";

  // bench model state
  int m_offi, m_offq, m_cw, m_set;
  bit m_pend, m_calq, m_short, m_uncal, e_vld;
  int e_i, e_q;

  always #2.5 clk = ~clk;

  dc_offset_cal #(.DATA_W(W), .CAL_MIN_CYC(MIN), .SETTLE_CYC(SET)) dut (
    .clk(clk), .rst(rst), .cal_i(cal), .sleep_a_i(sa), .sleep_b_i(sb),
    .res_vld_i(vld), .res_i_i(ri), .res_q_i(rq), .out_vld_o(out_vld),
    .out_i_o(oi), .out_q_o(oq), .cal_short_o(short_o), .uncal_o(uncal)
  );

  function automatic int clampw(int d);
    int hi = (1 << (W - 1)) - 1;
    int lo = -(1 << (W - 1));
    return (d > hi) ? hi : (d < lo) ? lo : d;
  endfunction

  function automatic int sv(logic [W-1:0] x);
    return int'($signed(x));
  endfunction

  task automatic check(bit ok, string tag, int act, int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    m_offi = 0; m_offq = 0; m_cw = 0; m_set = SET;
    m_pend = 0; m_calq = 0; m_short = 0; m_uncal = 1;
    e_vld = 0; e_i = 0; e_q = 0;
  endtask

  task automatic model_step();
    bit asl, ok, fall, pend, cap;
    int fi, fq;
    if (rst) begin
      model_reset();
      return;
    end
    asl  = sa | sb;
    ok   = vld && !asl && (m_set == SET);
    fall = m_calq && !cal;
    pend = m_pend || fall;
    cap  = pend && ok && !cal;
    fi   = cal ? 0 : cap ? sv(ri) : m_offi;
    fq   = cal ? 0 : cap ? sv(rq) : m_offq;
    e_vld = ok;
    if (ok) begin
      e_i = clampw(sv(ri) - fi);
      e_q = clampw(sv(rq) - fq);
    end
    m_offi = fi;
    m_offq = fq;
    m_pend = (cal || cap) ? 1'b0 : pend;
    if (fall) m_short = (m_cw < MIN);
    m_cw   = cal ? ((m_cw < MIN) ? m_cw + 1 : m_cw) : 0;
    m_set  = asl ? 0 : ((m_set < SET) ? m_set + 1 : m_set);
    if (cap) m_uncal = 0;
    m_calq = cal;
  endtask

  task automatic compare();
    check(out_vld == e_vld, {ph, " valid"}, int'(out_vld), int'(e_vld));
    check(sv(oi) == e_i, {ph, " I data"}, sv(oi), e_i);
    check(sv(oq) == e_q, {ph, " Q data"}, sv(oq), e_q);
    check(short_o == m_short, {ph, " short flag R5"}, int'(short_o), int'(m_short));
    check(uncal == m_uncal, {ph, " uncal R9"}, int'(uncal), int'(m_uncal));
  endtask

  task automatic cyc(bit c, bit a, bit b, bit v, int xi, int xq);
    @(negedge clk);
    cal = c; sa = a; sb = b; vld = v;
    ri = W'(xi); rq = W'(xq);
    model_step();
    @(posedge clk);
    #1;
    compare();
  endtask

  bit done = 0;
  initial begin
    #(5 * 150000);
    if (!done) begin
      nerr++; nchk++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  initial begin
    bit rc, ra, rb;
    model_reset();
    // R11 reset state
    ph = "R11";
    repeat (3) cyc(0, 0, 0, 0, 0, 0);
    check(uncal == 1 && out_vld == 0 && short_o == 0, "R11 reset state", int'(uncal), 1);
    rst = 1'b0;
    cyc(0, 0, 0, 1, 50, -50);
    check(sv(oi) == 50, "R11 zero offset after reset", sv(oi), 50);
    check(uncal == 1, "R9 set before calibration", int'(uncal), 1);

    // short strobe, values pass unchanged while high
    ph = "R1";
    repeat (9) cyc(1, 0, 0, 0, 0, 0);
    cyc(1, 0, 0, 1, 7, -7);
    check(sv(oi) == 7 && sv(oq) == -7, "R1 offset zero during strobe", sv(oi), 7);
    ph = "R4";
    cyc(0, 0, 0, 1, 30, -20);
    check(sv(oi) == 0 && sv(oq) == 0, "R4 captured result outputs zero", sv(oi), 0);
    check(short_o == 1, "R5 short strobe flagged", int'(short_o), 1);
    check(uncal == 0, "R9 cleared by capture", int'(uncal), 0);
    ph = "R3";
    cyc(0, 0, 0, 1, 100, -100);
    check(sv(oi) == 70 && sv(oq) == -80, "R3 subtraction", sv(oq), -80);
    ph = "R2";
    cyc(0, 0, 0, 1, 55, 0);
    check(sv(oi) == 25, "R2 single capture only", sv(oi), 25);

    // long strobe, late first result after release
    ph = "R6";
    repeat (24) cyc(1, 0, 0, 0, 0, 0);
    cyc(1, 0, 0, 1, 9, 9);
    check(sv(oi) == 9 && short_o == 1, "R6 long hold keeps offset zero", sv(oi), 9);
    ph = "R2";
    repeat (3) cyc(0, 0, 0, 0, 0, 0);
    check(short_o == 0, "R5 long strobe not flagged", int'(short_o), 0);
    cyc(0, 0, 0, 1, -100, 100);
    check(sv(oi) == 0, "R2 capture of first result after fall", sv(oi), 0);
    ph = "R10";
    cyc(0, 0, 0, 1, 100, -100);
    check(sv(oi) == 127 && sv(oq) == -128, "R10 saturation both ends", sv(oi), 127);

    // sleep holds offset, settle window drops results
    ph = "R7";
    repeat (4) cyc(0, 1, 0, 1, 5, 5);
    check(out_vld == 0, "R7 results ignored in sleep", int'(out_vld), 0);
    ph = "R8";
    repeat (SET) begin
      cyc(0, 0, 0, 1, 0, 0);
      check(out_vld == 0, "R8 dropped in settle window", int'(out_vld), 0);
    end
    cyc(0, 0, 0, 1, 0, 0);
    check(out_vld == 1 && sv(oi) == 100 && sv(oq) == -100,
          "R7 offset kept through sleep", sv(oi), 100);

    // constrained random
    ph = "R3 R5 R7 R8 random";
    void'($urandom(32'h1234_5678));
    rc = 0; ra = 0; rb = 0;
    for (int k = 0; k < 4000; k++) begin
      if ($urandom_range(39) == 0) rc = ~rc;
      if ($urandom_range(59) == 0) ra = ~ra;
      if ($urandom_range(79) == 0) rb = ~rb;
      cyc(rc, ra, rb, ($urandom_range(1) == 1),
          int'($urandom_range(255)) - 128, int'($urandom_range(255)) - 128);
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule